// File: doc/BRIEF.md
# Mixed-Cell Boundary-Scan Register

This block is a boundary-scan data register for a small group of device pins. Each pin contributes a group of scan cells that depends on its kind. An input-only pin has one observe cell. A plain output has one drive cell. A tri-stateable output has a drive cell and a high-impedance control cell. A bidirectional pad has all three cells. A packed parameter lists the pin kinds. The chain length and the position of every cell are derived from that list at elaboration.

A test access port controller, which lies outside this block, supplies the capture, shift and update strobes on the test clock. On capture, every shift stage loads a value. Observe cells take the live pad level. Drive cells take the core's functional output level. Control cells take the core's high-impedance request. On shift, the chain moves one place toward the serial output on each rising edge, and new data enters at the far end. On update, the drive and control cells copy their shift stages into hold latches on the falling edge. A test-mode input gives those latches control of the pads. While test mode is low, the pads follow the core.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds one cell per input-only or plain-output pin, two per tri-stateable output and three per bidirectional pin. Its length is the sum of these counts, so a bit entering at `tdi` reaches `tdo` after exactly that many shifts. Pin kind codes in `PIN_MAP[2p+1:2p]` are: 0 input-only, 1 plain output, 2 tri-stateable output, 3 bidirectional.
- R2: Pin 0 owns the cells nearest `tdo`, and higher-numbered pins follow. Inside one pin the cells run, with rising chain index, high-impedance control, then drive, then observe, each present only if the pin has it. Chain bit 0 is the first bit presented on `tdo`.
- R3: A rising `tck` with `capture_dr` high loads each observe cell from `pin_in[p]`, each drive cell from `core_out[p]` and each control cell from `core_hiz[p]`.
- R4: A rising `tck` with `shift_dr` high (and `capture_dr` low) moves every bit one index lower. `tdi` enters the highest index, and `tdo` always shows bit 0.
- R5: On a falling `tck` with `update_dr` high, every drive and control cell copies its shift-stage value into its hold latch.
- R6: While `test_mode` is 1, `pad_out[p]` equals the pin's drive latch. `pad_hiz[p]` equals its control latch (1 = high impedance) on pins that have one and is 0 on plain outputs. Input-only pins always give `pad_out`=0 and `pad_hiz`=1. Changes on `core_out`/`core_hiz` have no effect on the pads in this mode.
- R7: While `test_mode` is 0, output pins give `pad_out`=`core_out` and tri-stateable pins give `pad_hiz`=`core_hiz`. Plain outputs give `pad_hiz`=0, and the hold latches have no effect.
- R8: `rst` high, sampled on a `tck` edge, clears all hold latches and shift stages to 0. So in test mode after reset, every output pin is driven low.
- R9: With neither `capture_dr` nor `shift_dr`, the shift stages keep their values. Without `update_dr`, the hold latches keep theirs, so shifting in test mode does not disturb the pads.
- R10: When `capture_dr` and `shift_dr` are high together, the capture takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture and shift on rising edge, update on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| test_mode | input | 1 | 1: hold latches drive the pads; 0: core drives the pads |
| tdi | input | 1 | Serial data in, enters the highest chain index |
| tdo | output | 1 | Serial data out, chain bit 0 |
| pin_in | input | NPIN | Live pad levels observed by observe cells |
| core_out | input | NPIN | Core functional output levels |
| core_hiz | input | NPIN | Core high-impedance requests, 1 = release the pad |
| pad_out | output | NPIN | Level driven toward each pad |
| pad_hiz | output | NPIN | High-impedance control toward each pad, 1 = released |

## Verification
The bound checker watches the chain on every rising edge. It checks that a capture loads exactly the values presented to the cells and that a shift moves every bit one place with `tdi` entering on top. It checks that idle cycles leave the chain untouched, that the pads stay frozen in test mode between updates, and that the pads are low and driven right after reset. The order of the cells per pin kind, the serial length, the mapping of latched bits onto particular pads and the normal-mode pass-through can only be shown by the bench scenarios. In those scenarios, known pin patterns are captured and shifted out bit by bit, and chosen patterns are shifted in, updated and read back at the pads.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int MAX_PINS = 32;
    localparam int MAP_W    = 2 * MAX_PINS;

    typedef enum logic [1:0] {
        PIN_IN      = 2'd0,
        PIN_OUT     = 2'd1,
        PIN_OUT_TRI = 2'd2,
        PIN_BIDIR   = 2'd3
    } pin_kind_e;

    typedef enum logic [1:0] {
        CELL_HIZ = 2'd0,
        CELL_DRV = 2'd1,
        CELL_OBS = 2'd2
    } cell_kind_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    function automatic bit has_hiz(pin_kind_e k);
        return (k == PIN_OUT_TRI) || (k == PIN_BIDIR);
    endfunction

    function automatic bit has_drv(pin_kind_e k);
        return k != PIN_IN;
    endfunction

    function automatic bit has_obs(pin_kind_e k);
        return (k == PIN_IN) || (k == PIN_BIDIR);
    endfunction

    function automatic int cells_of(pin_kind_e k);
        return int'(has_hiz(k)) + int'(has_drv(k)) + int'(has_obs(k));
    endfunction

    // Cell kind at local index j of a pin: control, then drive, then observe.
    function automatic cell_kind_e cell_at(pin_kind_e k, int j);
        int n_hiz;
        int n_drv;
        n_hiz = int'(has_hiz(k));
        n_drv = int'(has_drv(k));
        if (j < n_hiz)
            return CELL_HIZ;
        else if (j < n_hiz + n_drv)
            return CELL_DRV;
        else
            return CELL_OBS;
    endfunction

    function automatic pin_kind_e kind_of(logic [MAP_W-1:0] map, int p);
        return pin_kind_e'(map[2*p +: 2]);
    endfunction

    function automatic int base_of(logic [MAP_W-1:0] map, int p);
        int s;
        s = 0;
        for (int q = 0; q < p; q++)
            s += cells_of(kind_of(map, q));
        return s;
    endfunction

    function automatic int chain_len(logic [MAP_W-1:0] map, int n);
        return base_of(map, n);
    endfunction

    function automatic logic [MAX_PINS-1:0] in_only_mask(logic [MAP_W-1:0] map, int n);
        logic [MAX_PINS-1:0] m;
        m = '0;
        for (int q = 0; q < n; q++)
            m[q] = (kind_of(map, q) == PIN_IN);
        return m;
    endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_OBS
) (
    input  logic      tck,
    input  logic      rst,
    input  scan_ctl_t ctl,
    input  logic      cap_val,
    input  logic      si,
    output logic      sq,
    output logic      uq
);

    always_ff @(posedge tck) begin
        if (rst)
            sq <= 1'b0;
        else if (ctl.capture)
            sq <= cap_val;
        else if (ctl.shift)
            sq <= si;
    end

    generate
        if (KIND == CELL_OBS) begin : g_no_latch
            logic unused_upd;
            assign unused_upd = ctl.update;
            assign uq = 1'b0;
        end else begin : g_latch
            logic hold_q;
            always_ff @(negedge tck) begin
                if (rst)
                    hold_q <= 1'b0;
                else if (ctl.update)
                    hold_q <= sq;
            end
            assign uq = hold_q;
        end
    endgenerate

endmodule

// File: rtl/bsr_pin.sv
module bsr_pin
    import bsr_pkg::*;
#(
    parameter pin_kind_e KIND = PIN_BIDIR,
    parameter int        W    = 3
) (
    input  logic         tck,
    input  logic         rst,
    input  scan_ctl_t    ctl,
    input  logic         test_mode,
    input  logic         pin_in,
    input  logic         core_out,
    input  logic         core_hiz,
    input  logic         si,
    output logic         so,
    output logic [W-1:0] cap_vec,
    output logic [W-1:0] sq_vec,
    output logic         pad_out,
    output logic         pad_hiz
);

    logic [W-1:0] q;
    logic [W-1:0] u;
    logic [W-1:0] sin;

    generate
        if (W == 1) begin : g_one
            assign sin = si;
        end else begin : g_many
            assign sin = {si, q[W-1:1]};
        end

        for (genvar j = 0; j < W; j++) begin : g_cell
            localparam cell_kind_e CK = cell_at(KIND, j);
            if (CK == CELL_OBS) begin : g_obs
                assign cap_vec[j] = pin_in;
            end else if (CK == CELL_DRV) begin : g_drv
                assign cap_vec[j] = core_out;
            end else begin : g_hiz
                assign cap_vec[j] = core_hiz;
            end
            bsr_cell #(.KIND(CK)) u_cell (
                .tck     (tck),
                .rst     (rst),
                .ctl     (ctl),
                .cap_val (cap_vec[j]),
                .si      (sin[j]),
                .sq      (q[j]),
                .uq      (u[j])
            );
        end

        if (KIND == PIN_IN) begin : g_pad_in
            assign pad_out = 1'b0;
            assign pad_hiz = 1'b1;
        end else if (KIND == PIN_OUT) begin : g_pad_out
            assign pad_out = test_mode ? u[0] : core_out;
            assign pad_hiz = 1'b0;
        end else begin : g_pad_tri
            assign pad_out = test_mode ? u[1] : core_out;
            assign pad_hiz = test_mode ? u[0] : core_hiz;
        end
    endgenerate

    logic unused_sink;
    assign unused_sink = ^{u, pin_in, core_out, core_hiz, test_mode};

    assign so     = q[0];
    assign sq_vec = q;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int              NPIN    = 6,
    parameter logic [2*NPIN-1:0] PIN_MAP = 12'h39C
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            test_mode,
    input  logic            tdi,
    output logic            tdo,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] core_out,
    input  logic [NPIN-1:0] core_hiz,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_hiz
);

    localparam logic [MAP_W-1:0] MAP_X = MAP_W'(PIN_MAP);
    localparam int               LEN   = chain_len(MAP_X, NPIN);

    scan_ctl_t        ctl;
    logic [NPIN:0]    link;
    logic [LEN-1:0]   chain_q;
    logic [LEN-1:0]   chain_cap;

    assign ctl      = '{capture: capture_dr, shift: shift_dr, update: update_dr};
    assign link[NPIN] = tdi;

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            localparam pin_kind_e K = kind_of(MAP_X, p);
            localparam int        B = base_of(MAP_X, p);
            localparam int        W = cells_of(K);
            bsr_pin #(.KIND(K), .W(W)) u_pin (
                .tck       (tck),
                .rst       (rst),
                .ctl       (ctl),
                .test_mode (test_mode),
                .pin_in    (pin_in[p]),
                .core_out  (core_out[p]),
                .core_hiz  (core_hiz[p]),
                .si        (link[p+1]),
                .so        (link[p]),
                .cap_vec   (chain_cap[B +: W]),
                .sq_vec    (chain_q[B +: W]),
                .pad_out   (pad_out[p]),
                .pad_hiz   (pad_hiz[p])
            );
        end
    endgenerate

    assign tdo = link[0];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
    import bsr_pkg::*;
#(
    parameter int                NPIN    = 6,
    parameter logic [2*NPIN-1:0] PIN_MAP = 12'h39C,
    parameter int                LEN     = 11
) (
    input logic            tck,
    input logic            rst,
    input logic            capture_dr,
    input logic            shift_dr,
    input logic            update_dr,
    input logic            test_mode,
    input logic            tdi,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_hiz,
    input logic [LEN-1:0]  chain_q,
    input logic [LEN-1:0]  chain_cap
);

    localparam logic [MAX_PINS-1:0] IN_FULL = in_only_mask(MAP_W'(PIN_MAP), NPIN);
    localparam logic [NPIN-1:0]     IN_MASK = IN_FULL[NPIN-1:0];

    // R3, R10: capture loads the presented values, even with shift high
    p_capture_load_r3: assert property (@(posedge tck) disable iff (rst)
        capture_dr |=> chain_q == $past(chain_cap));

    // R4: shift moves toward tdo with tdi entering on top
    p_shift_move_r4: assert property (@(posedge tck) disable iff (rst)
        (shift_dr && !capture_dr) |=> chain_q == $past({tdi, chain_q[LEN-1:1]}));

    // R9: idle cycles leave the shift stages unchanged
    p_idle_hold_r9: assert property (@(posedge tck) disable iff (rst)
        (!shift_dr && !capture_dr) |=> $stable(chain_q));

    // R9, R6: pads frozen in test mode without an update
    p_pads_frozen_r9: assert property (@(posedge tck) disable iff (rst)
        (test_mode && $past(test_mode) && !update_dr) |-> ($stable(pad_out) && $stable(pad_hiz)));

    // R8: right after reset, test-mode pads are low and driven
    p_reset_clear_r8: assert property (@(posedge tck) disable iff (rst)
        ($fell(rst) && test_mode && !update_dr) |-> (pad_out == '0 && pad_hiz == IN_MASK));

endmodule

bind bsr_chain bsr_chain_chk #(.NPIN(NPIN), .PIN_MAP(PIN_MAP), .LEN(LEN)) i_chk (
    .tck        (tck),
    .rst        (rst),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .test_mode  (test_mode),
    .tdi        (tdi),
    .pad_out    (pad_out),
    .pad_hiz    (pad_hiz),
    .chain_q    (chain_q),
    .chain_cap  (chain_cap)
);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;

    localparam int              NPIN = 6;
    localparam logic [11:0]     MAP  = 12'h39C;

    function automatic int kind(int p);
        return int'(MAP[2*p +: 2]);
    endfunction
    function automatic bit k_hiz(int k); return k >= 2; endfunction
    function automatic bit k_drv(int k); return k != 0; endfunction
    function automatic bit k_obs(int k); return (k == 0) || (k == 3); endfunction

    function automatic int bench_len();
        int s;
        s = 0;
        for (int p = 0; p < NPIN; p++)
            s += int'(k_hiz(kind(p))) + int'(k_drv(kind(p))) + int'(k_obs(kind(p)));
        return s;
    endfunction

    localparam int LEN = bench_len();

    logic            tck = 1'b0;
    logic            rst, capture_dr, shift_dr, update_dr, test_mode, tdi;
    logic            tdo;
    logic [NPIN-1:0] pin_in, core_out, core_hiz, pad_out, pad_hiz;

    int checks = 0;
    int errors = 0;

    always #5 tck = ~tck;

    bsr_chain #(.NPIN(NPIN), .PIN_MAP(MAP)) i_bsr_chain (
        .tck(tck), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .test_mode(test_mode), .tdi(tdi), .tdo(tdo),
        .pin_in(pin_in), .core_out(core_out), .core_hiz(core_hiz),
        .pad_out(pad_out), .pad_hiz(pad_hiz)
    );

    // Expected captured chain: per pin control, drive, observe; pin 0 lowest.
    function automatic logic [31:0] exp_cap(logic [NPIN-1:0] pi, logic [NPIN-1:0] co,
                                            logic [NPIN-1:0] ch);
        logic [31:0] v;
        int idx;
        v = '0;
        idx = 0;
        for (int p = 0; p < NPIN; p++) begin
            if (k_hiz(kind(p))) begin v[idx] = ch[p]; idx++; end
            if (k_drv(kind(p))) begin v[idx] = co[p]; idx++; end
            if (k_obs(kind(p))) begin v[idx] = pi[p]; idx++; end
        end
        return v;
    endfunction

    // Expected pads from latched vector v (test mode) or core (normal mode).
    function automatic logic [2*NPIN-1:0] exp_pads(logic [31:0] v, bit tm,
                                                   logic [NPIN-1:0] co, logic [NPIN-1:0] ch);
        logic [NPIN-1:0] po, ph;
        int idx, k;
        logic eb, ob;
        idx = 0;
        for (int p = 0; p < NPIN; p++) begin
            k = kind(p);
            eb = 1'b0;
            ob = 1'b0;
            if (k_hiz(k)) begin eb = v[idx]; idx++; end
            if (k_drv(k)) begin ob = v[idx]; idx++; end
            if (k_obs(k)) idx++;
            if (k == 0) begin
                po[p] = 1'b0; ph[p] = 1'b1;
            end else if (tm) begin
                po[p] = ob; ph[p] = eb;
            end else begin
                po[p] = co[p]; ph[p] = k_hiz(k) ? ch[p] : 1'b0;
            end
        end
        return {ph, po};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #2;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    task automatic shift_word(input logic [31:0] din, input int n, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            shift_dr = 1'b1;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] dout, din, v, exp;
        logic [2*NPIN-1:0] pads, held;
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        rst = 1'b1; capture_dr = 0; shift_dr = 0; update_dr = 0;
        test_mode = 1'b1; tdi = 0; pin_in = '0; core_out = '1; core_hiz = '1;
        repeat (4) tick();
        // R8: reset clears latches; test-mode pads low and driven
        check({pad_hiz, pad_out} == exp_pads('0, 1'b1, core_out, core_hiz), "R8 reset pads",
              32'({pad_hiz, pad_out}), 32'(exp_pads('0, 1'b1, core_out, core_hiz)));
        rst = 1'b0;
        tick();
        check(tdo == 1'b0, "R8 reset chain", 32'(tdo), 32'd0);

        // R1 R2 R3 R4: capture then shift out, random patterns
        for (int it = 0; it < 8; it++) begin
            pin_in = NPIN'($urandom); core_out = NPIN'($urandom); core_hiz = NPIN'($urandom);
            exp = exp_cap(pin_in, core_out, core_hiz);
            din = $urandom;
            do_capture();
            shift_word(din, LEN + 4, dout);
            check(dout[LEN-1:0] == exp[LEN-1:0], "R2 R3 R4 capture order",
                  32'(dout[LEN-1:0]), 32'(exp[LEN-1:0]));
            check(dout[LEN +: 4] == din[3:0], "R1 chain length",
                  32'(dout[LEN +: 4]), 32'(din[3:0]));
        end

        // Directed: all ones on observe pins, zeros elsewhere
        pin_in = '1; core_out = '0; core_hiz = '0;
        exp = exp_cap(pin_in, core_out, core_hiz);
        do_capture();
        shift_word('0, LEN, dout);
        check(dout[LEN-1:0] == exp[LEN-1:0], "R2 observe cell positions",
              32'(dout[LEN-1:0]), 32'(exp[LEN-1:0]));

        // R10: capture and shift together, capture wins
        pin_in = NPIN'(6'b101101); core_out = NPIN'(6'b010110); core_hiz = NPIN'(6'b110011);
        exp = exp_cap(pin_in, core_out, core_hiz);
        capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        tick();
        capture_dr = 1'b0; shift_dr = 1'b0;
        // R9: idle cycles keep the captured bits
        repeat (3) tick();
        shift_word('0, LEN, dout);
        check(dout[LEN-1:0] == exp[LEN-1:0], "R10 R9 capture priority and hold",
              32'(dout[LEN-1:0]), 32'(exp[LEN-1:0]));

        // R5 R6 R9: load, update, test-mode pads
        test_mode = 1'b1;
        v = '0;
        for (int it = 0; it < 8; it++) begin
            held = {pad_hiz, pad_out};
            v = $urandom;
            shift_word(v, LEN, dout);
            check({pad_hiz, pad_out} == held, "R9 pads stable while shifting",
                  32'({pad_hiz, pad_out}), 32'(held));
            do_update();
            core_out = NPIN'($urandom); core_hiz = NPIN'($urandom);
            #1;
            pads = exp_pads(v, 1'b1, core_out, core_hiz);
            check({pad_hiz, pad_out} == pads, "R5 R6 test-mode pads",
                  32'({pad_hiz, pad_out}), 32'(pads));
        end

        // R7: normal mode follows core, latches ignored
        test_mode = 1'b0;
        for (int it = 0; it < 6; it++) begin
            core_out = NPIN'($urandom); core_hiz = NPIN'($urandom);
            tick();
            pads = exp_pads(v, 1'b0, core_out, core_hiz);
            check({pad_hiz, pad_out} == pads, "R7 normal-mode pads",
                  32'({pad_hiz, pad_out}), 32'(pads));
        end

        // R5 R7: update while in normal mode, then latches appear in test mode
        v = 32'h0000_05A5;
        shift_word(v, LEN, dout);
        do_update();
        pads = exp_pads(v, 1'b0, core_out, core_hiz);
        check({pad_hiz, pad_out} == pads, "R7 update hidden in normal mode",
              32'({pad_hiz, pad_out}), 32'(pads));
        test_mode = 1'b1;
        #1;
        pads = exp_pads(v, 1'b1, core_out, core_hiz);
        check({pad_hiz, pad_out} == pads, "R5 latched values shown",
              32'({pad_hiz, pad_out}), 32'(pads));

        // R8: reset in test mode after nonzero latches
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        tick();
        pads = exp_pads('0, 1'b1, core_out, core_hiz);
        check({pad_hiz, pad_out} == pads, "R8 reset after load",
              32'({pad_hiz, pad_out}), 32'(pads));

        finish_run();
    end

endmodule